// File: doc/BRIEF.md
# Noise-Shaping Requantizer with Segmented DAC Decoder

This block sits between a four-times up-sampling filter and a segmented current DAC. On every four-times-rate strobe it takes one 22-bit two's-complement sample per channel. A first-order error-feedback noise shaper cuts each sample to 15 bits. The seven bits that the cut throws away are kept per channel and added to that channel's next sample. The shaped sum is clipped to the 15-bit range, so it never wraps.

The 15-bit result is split into the control fields of a segmented current DAC:
- a direction bit, which is the word's sign;
- a 5-bit coarse field, decoded into a thermometer code that enables coarse current sources;
- a 9-bit fine field, which picks a fraction of one coarse current.

Every output is held in a register that loads only on the strobe. The analog stage therefore sees fields that all change on the same edge. The channel count is a parameter; the default is four.

Top module: `nsd_dac_front`

## Requirements
- R1: A synchronous active-low reset clears every output (word, direction, thermometer, fine) to zero and clears each channel's error store to zero.
- R2: Outputs and error stores change only on a clock edge where `strobe` is high; with `strobe` low they hold whatever `din` does.
- R3: On a strobe, each channel's word is floor((x + e) / 128), where x is the signed 22-bit input and e is the unsigned 7-bit store. e holds the low 7 bits of that channel's previous sum, or 0 after reset.
- R4: The shaped result saturates: values above 16383 give 0x3FFF and values below -16384 give 0x4000; a non-negative input never yields a negative word.
- R5: The direction output of a channel equals bit 14 (the sign) of its 15-bit word.
- R6: The coarse field is word bits 13..9. Thermometer line j (0..31, line 0 at the lowest bit of the channel's slice) is on exactly when the coarse value exceeds j. Thus a coarse value k lights lines 0..k-1, zero lights none, and line 31 stays off.
- R7: The fine output of a channel equals word bits 8..0.
- R8: Channels are independent: each has its own error store and its own output slice, with channel c at bits [c*W +: W] of each bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| strobe | input | 1 | Four-times-rate load enable |
| din | input | NUM_CH*22 | Input samples, two's complement, channel c at [c*22 +: 22] |
| word_o | output | NUM_CH*15 | Requantized words |
| dir_o | output | NUM_CH | Current direction (sign) per channel |
| therm_o | output | NUM_CH*32 | Coarse thermometer lines |
| fine_o | output | NUM_CH*9 | Fine fraction select |

## Verification
Each pattern is aimed at a different fault:
- All-zero input separates a clean reset and a cleared error store from stale state.
- A constant input with set low bits (64 and 192) forces the store to carry over between samples, which separates true error feedback from plain truncation.
- Full-scale positive input applied repeatedly drives the sum past the 15-bit limit, which separates saturation from wrap. Full-scale negative input checks the bottom code.
- Pseudo-random and ramp samples on different channels sweep every coarse code and fine pattern. They also catch crosstalk between channel error stores.
- Input changes with the strobe low show that nothing loads off-strobe.

// File: rtl/nsd_pkg.sv
// Package: shared defaults and the saturation state type of the requantizer.
// Assumes: all lanes use the same widths, taken from these defaults.
package nsd_pkg;
    localparam int DEF_IN_W     = 22;
    localparam int DEF_COARSE_W = 5;
    localparam int DEF_FINE_W   = 9;
    localparam int DEF_NUM_CH   = 4;

    // Which way, if any, the shaped sum was clipped
    typedef enum logic [1:0] {
        SAT_NONE = 2'd0,
        SAT_HI   = 2'd1,
        SAT_LO   = 2'd2
    } sat_e;
endpackage

// File: rtl/nsd_shaper.sv
// Module: first-order error-feedback requantizer for one channel.
// Adds the previous discarded LSBs to the sample, truncates toward minus
// infinity, saturates to OUT_W bits. Word output is combinational; the
// error store loads on strobe. Assumes IN_W > OUT_W.
module nsd_shaper
    import nsd_pkg::*;
#(
    parameter int IN_W  = DEF_IN_W,
    parameter int OUT_W = 1 + DEF_COARSE_W + DEF_FINE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] word_nxt
);
    localparam int DROP_W = IN_W - OUT_W;
    localparam logic [OUT_W-1:0] WORD_MAX = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] WORD_MIN = {1'b1, {(OUT_W-1){1'b0}}};

    logic [DROP_W-1:0] err_q;
    logic [IN_W:0]     sum;
    logic [OUT_W:0]    quot;
    sat_e              sat;

    // Add the stored error to the sign-extended sample and take the top bits
    always_comb begin
        sum  = {din[IN_W-1], din} + {{(OUT_W+1){1'b0}}, err_q};
        quot = sum[IN_W:DROP_W];
    end

    // Detect overflow of the OUT_W range: top two bits of quot differ
    always_comb begin
        if (quot[OUT_W] == quot[OUT_W-1]) sat = SAT_NONE;
        else if (!quot[OUT_W])            sat = SAT_HI;
        else                              sat = SAT_LO;
    end

    // Pick the clipped or plain word
    always_comb begin
        case (sat)
            SAT_HI:  word_nxt = WORD_MAX;
            SAT_LO:  word_nxt = WORD_MIN;
            default: word_nxt = quot[OUT_W-1:0];
        endcase
    end

    // Keep the discarded LSBs for the next sample of this channel
    always_ff @(posedge clk) begin
        if (!rst_n)      err_q <= '0;
        else if (strobe) err_q <= sum[DROP_W-1:0];
    end

    // R2
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(err_q));

    // R4
    sat_hi_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!din[IN_W-1]) |-> !word_nxt[OUT_W-1]);
endmodule

// File: rtl/nsd_therm.sv
// Module: binary-to-thermometer decoder for the coarse field.
// Line j is on when the code exceeds j; the top line is therefore never on.
module nsd_therm
    import nsd_pkg::*;
#(
    parameter int COARSE_W = DEF_COARSE_W
) (
    input  logic [COARSE_W-1:0]       code,
    output logic [(1<<COARSE_W)-1:0]  lines
);
    localparam int THERM_W = 1 << COARSE_W;

    // One comparator per line
    for (genvar j = 0; j < THERM_W; j++) begin : g_line
        assign lines[j] = (32'(code) > j);
    end
endmodule

// File: rtl/nsd_lane.sv
// Module: one channel: shaper, thermometer decode and the strobe-loaded
// output latch holding word and thermometer lines.
module nsd_lane
    import nsd_pkg::*;
#(
    parameter int IN_W     = DEF_IN_W,
    parameter int COARSE_W = DEF_COARSE_W,
    parameter int FINE_W   = DEF_FINE_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      strobe,
    input  logic [IN_W-1:0]           din,
    output logic [COARSE_W+FINE_W:0]  word_q,
    output logic                      dir,
    output logic [(1<<COARSE_W)-1:0]  therm_q,
    output logic [FINE_W-1:0]         fine
);
    localparam int OUT_W   = 1 + COARSE_W + FINE_W;
    localparam int THERM_W = 1 << COARSE_W;

    logic [OUT_W-1:0]   word_nxt;
    logic [THERM_W-1:0] therm_nxt;

    nsd_shaper #(.IN_W(IN_W), .OUT_W(OUT_W)) u_shaper (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (strobe),
        .din      (din),
        .word_nxt (word_nxt)
    );

    nsd_therm #(.COARSE_W(COARSE_W)) u_therm (
        .code  (word_nxt[OUT_W-2:FINE_W]),
        .lines (therm_nxt)
    );

    // Latch word and thermometer lines together on the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            therm_q <= '0;
        end else if (strobe) begin
            word_q  <= word_nxt;
            therm_q <= therm_nxt;
        end
    end

    // Fields taken straight from the registered word
    assign dir  = word_q[OUT_W-1];
    assign fine = word_q[FINE_W-1:0];

    // R2
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> ($stable(word_q) && $stable(therm_q)));

    // R6
    therm_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(therm_q) == 32'(word_q[OUT_W-2:FINE_W]));

    // R6
    therm_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((therm_q & (therm_q + 1'b1)) == '0) && !therm_q[THERM_W-1]);

    // R4
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !din[IN_W-1]) |=> !word_q[OUT_W-1]);

    // R1: after a reset edge everything reads zero
    logic was_rst;
    always_ff @(posedge clk) was_rst <= !rst_n;
    always @(negedge clk) begin
        if (was_rst) begin
            // R1
            reset_clear_chk: assert (word_q == '0 && therm_q == '0);
        end
    end
endmodule

// File: rtl/nsd_dac_front.sv
// Module: top of the requantizer/decoder; one lane per channel, buses
// packed with channel c at slice c.
module nsd_dac_front
    import nsd_pkg::*;
#(
    parameter int IN_W     = DEF_IN_W,
    parameter int COARSE_W = DEF_COARSE_W,
    parameter int FINE_W   = DEF_FINE_W,
    parameter int NUM_CH   = DEF_NUM_CH
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                strobe,
    input  logic [NUM_CH*IN_W-1:0]              din,
    output logic [NUM_CH*(1+COARSE_W+FINE_W)-1:0] word_o,
    output logic [NUM_CH-1:0]                   dir_o,
    output logic [NUM_CH*(1<<COARSE_W)-1:0]     therm_o,
    output logic [NUM_CH*FINE_W-1:0]            fine_o
);
    localparam int OUT_W   = 1 + COARSE_W + FINE_W;
    localparam int THERM_W = 1 << COARSE_W;

    // One independent lane per channel
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        nsd_lane #(
            .IN_W     (IN_W),
            .COARSE_W (COARSE_W),
            .FINE_W   (FINE_W)
        ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .strobe  (strobe),
            .din     (din[c*IN_W +: IN_W]),
            .word_q  (word_o[c*OUT_W +: OUT_W]),
            .dir     (dir_o[c]),
            .therm_q (therm_o[c*THERM_W +: THERM_W]),
            .fine    (fine_o[c*FINE_W +: FINE_W])
        );
    end
endmodule

// File: tb/test_nsd_dac_front.sv
`timescale 1ns/1ps
module test_nsd_dac_front;
    localparam int NCH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strobe = 1'b0;
    logic [NCH*22-1:0] din = '0;
    logic [NCH*15-1:0] word_o;
    logic [NCH-1:0]    dir_o;
    logic [NCH*32-1:0] therm_o;
    logic [NCH*9-1:0]  fine_o;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    nsd_dac_front i_nsd_dac_front (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .din(din),
        .word_o(word_o), .dir_o(dir_o), .therm_o(therm_o), .fine_o(fine_o)
    );

    typedef logic [NCH-1:0][14:0] exp_t;
    exp_t exp_q[$];
    exp_t last_exp = '0;
    logic [6:0] m_err [NCH];
    logic due = 1'b0;
    logic [31:0] lfsr = 32'h1234_5678;

    // Reference model of R3/R4 for one channel
    function automatic logic [14:0] model(input int ch, input logic [21:0] s);
        logic signed [22:0] sum;
        logic signed [15:0] qq;
        sum = $signed({s[21], s}) + $signed({16'b0, m_err[ch]});
        m_err[ch] = sum[6:0];
        qq = sum[22:7];
        if (qq > 16'sd16383)  return 15'h3FFF;
        if (qq < -16'sd16384) return 15'h4000;
        return qq[14:0];
    endfunction

    function automatic logic [31:0] therm_of(input logic [14:0] w);
        logic [31:0] t;
        for (int j = 0; j < 32; j++) t[j] = (int'(w[13:9]) > j);
        return t;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic compare_all(input exp_t e, input string what);
        for (int c = 0; c < NCH; c++) begin
            check($sformatf("R3 R4 R8 %s word ch%0d", what, c), 32'(word_o[c*15 +: 15]), 32'(e[c]));
            check($sformatf("R5 %s dir ch%0d", what, c), 32'(dir_o[c]), 32'(e[c][14]));
            check($sformatf("R6 %s therm ch%0d", what, c), therm_o[c*32 +: 32], therm_of(e[c]));
            check($sformatf("R7 %s fine ch%0d", what, c), 32'(fine_o[c*9 +: 9]), 32'(e[c][8:0]));
        end
    endtask

    // Driver: apply one strobed sample set and queue the expectation
    task automatic drive(input logic [NCH-1:0][21:0] s);
        exp_t e;
        @(negedge clk);
        for (int c = 0; c < NCH; c++) e[c] = model(c, s[c]);
        din = s;
        strobe = 1'b1;
        exp_q.push_back(e);
        @(negedge clk);
        strobe = 1'b0;
    endtask

    // Monitor: results appear after the strobe edge, sampled at the next negedge
    always @(posedge clk) due <= strobe && rst_n;
    always @(negedge clk) begin
        if (due) begin
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R2 unexpected result actual=update expected=none");
            end else begin
                last_exp = exp_q.pop_front();
                compare_all(last_exp, "strobe");
            end
        end
    end

    function automatic logic [21:0] rnd22();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        return lfsr[21:0];
    endfunction

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [NCH-1:0][21:0] s;
        for (int c = 0; c < NCH; c++) m_err[c] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        rst_n = 1'b1;
        @(negedge clk);
        compare_all('0, "R1 reset");

        // Zero input
        drive('0);
        // Carry-over pattern: 64 then 192 on different channels (R3)
        for (int k = 0; k < 6; k++) begin
            s[0] = 22'd64; s[1] = 22'd192; s[2] = -22'sd64; s[3] = 22'd1;
            drive(s);
        end
        // Saturation pattern (R4)
        for (int k = 0; k < 4; k++) begin
            s[0] = 22'h1FFFFF; s[1] = 22'h200000; s[2] = 22'h1FFFC0; s[3] = 22'h200001;
            drive(s);
        end
        // Ramp sweeping coarse codes (R6)
        for (int k = 0; k < 40; k++) begin
            for (int c = 0; c < NCH; c++) s[c] = 22'((k * 512 + c * 3) << 7) ^ 22'(c * 17);
            drive(s);
        end
        // Random
        for (int k = 0; k < 200; k++) begin
            for (int c = 0; c < NCH; c++) s[c] = rnd22();
            drive(s);
        end

        // R2: input changes without strobe have no effect
        @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            din = {rnd22(), rnd22(), rnd22(), rnd22()};
            @(negedge clk);
            compare_all(last_exp, "R2 hold");
        end
        // Error store untouched by those cycles: next strobe follows the model
        for (int c = 0; c < NCH; c++) s[c] = 22'd100 + 22'(c);
        drive(s);
        drive(s);

        // R1: reset mid-run, then error store must read zero
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        compare_all('0, "R1 midreset");
        rst_n = 1'b1;
        for (int c = 0; c < NCH; c++) m_err[c] = '0;
        for (int c = 0; c < NCH; c++) s[c] = 22'd127;
        drive(s);
        drive(s);

        repeat (3) @(negedge clk);
        check("R2 queue drained", 32'(exp_q.size()), 32'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule